// File: doc/BRIEF.md
# Privileged Instruction Permission Gate

This block decides, for one privileged instruction presented per cycle, whether the instruction may execute, must raise an illegal-instruction exception, or must raise a virtual-instruction exception. It is purely combinational. The decode stage supplies a small opcode class, the current privilege level, whether the hart runs virtualized, a strap telling whether supervisor mode is implemented, and five trap-control bits. The bits cover timeout-wait trapping, virtual-memory trapping, their guest-level counterparts, and user access to hypervisor loads and stores.

The covered instructions are wait-for-interrupt, wait-on-reservation-set without timeout, the supervisor address-translation fence, the two hypervisor fences (guest virtual and guest physical) and the hypervisor guest loads and stores. The block only gives the verdict. When wait-for-interrupt is permitted, it also raises a halt request. Executing the fence or the memory access is left to the surrounding pipeline.

Top module: `priv_insn_gate`

## Requirements
- R1: The opcode class is 3 bits: 0 none, 1 wait-for-interrupt, 2 wait-on-reservation, 3 supervisor fence, 4 guest-virtual fence, 5 guest-physical fence, 6 hypervisor load/store, 7 reserved. Class 0 and class 7 drive allow, exc_valid, halt_req and exc_cause all to zero.
- R2: Wait-for-interrupt is illegal in three cases: trap_wait is set and the privilege is S; trap_wait is set, the privilege is U and no supervisor mode exists; or the hart is non-virtualized U while supervisor mode exists.
- R3: A wait-for-interrupt that R2 does not make illegal raises a virtual-instruction exception when virtualized in U, or when virtualized in S with vtrap_wait set. Otherwise it is allowed and halt_req is 1. halt_req is 0 for every other class.
- R4: Wait-on-reservation raises a virtual-instruction exception when virtualized in S or U with vtrap_wait set and trap_wait clear. Otherwise it is illegal when the privilege is not M and trap_wait is set. In every remaining case it is allowed.
- R5: The supervisor fence is illegal when not virtualized and either in U, or in S with trap_vm set. When virtualized, it raises a virtual-instruction exception in U or when vtrap_vm is set. Otherwise it is allowed.
- R6: The guest-virtual fence raises a virtual-instruction exception whenever virtualized. If not virtualized, it is allowed in M or S and illegal in U.
- R7: The guest-physical fence is illegal in non-virtualized S with trap_vm set. Otherwise it follows R6.
- R8: Hypervisor loads and stores are allowed in M regardless of every other input. Outside M they raise a virtual-instruction exception when virtualized, are illegal in non-virtualized U with hyp_user_ok clear, and are allowed otherwise.
- R9: Privilege is encoded U=0, S=1, M=3, and the value 2 is not driven. allow and exc_valid are never both 1. exc_cause is 2 for illegal instruction, 22 for virtual instruction, and 0 when exc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 3 | Privileged opcode class (R1 encoding) |
| priv | input | 2 | Current privilege, U=0, S=1, M=3 |
| virt_on | input | 1 | Hart runs virtualized |
| smode_present | input | 1 | Supervisor mode is implemented |
| trap_wait | input | 1 | Trap timeout waits to higher level |
| trap_vm | input | 1 | Trap virtual-memory operations from S |
| vtrap_wait | input | 1 | Trap guest waits to the hypervisor |
| vtrap_vm | input | 1 | Trap guest virtual-memory operations to the hypervisor |
| hyp_user_ok | input | 1 | Non-virtualized U may use hypervisor loads/stores |
| allow | output | 1 | Instruction may execute |
| exc_valid | output | 1 | Instruction raises an exception |
| exc_cause | output | CAUSE_W | Exception code (2 or 22) |
| halt_req | output | 1 | Permitted wait-for-interrupt: stall until interrupt |

## Verification
The bench sweeps every opcode class against every legal privilege level. For each pair it applies all 128 combinations of the virtualization flag, the supervisor strap and the five control bits. Toggling a single control bit, with everything else fixed, separates the illegal rules from the virtual rules. Examples are trap_wait against vtrap_wait for the two waits, trap_vm against vtrap_vm for the fences, and hyp_user_ok in U against M. Because the cases are ordered, the sweep also shows which rule wins where two overlap: an illegal verdict taking precedence over a virtual one for wait-for-interrupt, and M overriding virtualization for hypervisor loads and stores. The reserved and none classes are included in the same sweep to confirm that they never assert any output.

// File: rtl/priv_gate_pkg.sv
// Shared types for the privileged instruction permission gate.
// Assumes privilege value 2 is never presented.
package priv_gate_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        OPC_NONE     = 3'd0,
        OPC_WAIT_IRQ = 3'd1,
        OPC_WAIT_RSV = 3'd2,
        OPC_SFENCE   = 3'd3,
        OPC_HFENCE_V = 3'd4,
        OPC_HFENCE_G = 3'd5,
        OPC_HYP_LDST = 3'd6,
        OPC_RSVD     = 3'd7
    } opc_e;

    // One verdict per instruction: exactly one of allow/ill/vflt when used.
    typedef struct packed {
        logic allow;
        logic ill;
        logic vflt;
        logic halt;
    } verdict_t;

    localparam verdict_t VERDICT_NONE  = '0;
    localparam verdict_t VERDICT_ALLOW = '{allow: 1'b1, ill: 1'b0, vflt: 1'b0, halt: 1'b0};
    localparam verdict_t VERDICT_ILL   = '{allow: 1'b0, ill: 1'b1, vflt: 1'b0, halt: 1'b0};
    localparam verdict_t VERDICT_VFLT  = '{allow: 1'b0, ill: 1'b0, vflt: 1'b1, halt: 1'b0};
    localparam verdict_t VERDICT_HALT  = '{allow: 1'b1, ill: 1'b0, vflt: 1'b0, halt: 1'b1};

endpackage

// File: rtl/priv_wait_rules.sv
// Verdicts for the two wait instructions (wait-for-interrupt and
// wait-on-reservation without timeout). Combinational; assumes the
// privilege input never carries the reserved value.
module priv_wait_rules
    import priv_gate_pkg::*;
(
    input  priv_e    priv,
    input  logic     virt_on,
    input  logic     smode_present,
    input  logic     trap_wait,
    input  logic     vtrap_wait,
    output verdict_t v_wait_irq,
    output verdict_t v_wait_rsv
);

    logic in_u;
    logic in_s;
    logic in_m;

    // Decode privilege once for both rule sets.
    always_comb begin
        in_u = (priv == PRIV_USER);
        in_s = (priv == PRIV_SUPER);
        in_m = (priv == PRIV_MACH);
    end

    // Wait-for-interrupt: illegal checks first, then guest checks, else halt.
    always_comb begin
        if (((in_s || (!smode_present && in_u)) && trap_wait) ||
            (smode_present && in_u && !virt_on)) begin
            v_wait_irq = VERDICT_ILL;
        end else if (virt_on && (in_u || (in_s && vtrap_wait))) begin
            v_wait_irq = VERDICT_VFLT;
        end else begin
            v_wait_irq = VERDICT_HALT;
        end
    end

    // Wait-on-reservation: guest trap first, then the plain trap.
    always_comb begin
        if (virt_on && (in_s || in_u) && vtrap_wait && !trap_wait) begin
            v_wait_rsv = VERDICT_VFLT;
        end else if (!in_m && trap_wait) begin
            v_wait_rsv = VERDICT_ILL;
        end else begin
            v_wait_rsv = VERDICT_ALLOW;
        end
    end

    // Guard the properties of both verdicts.
    always_comb begin
        a_r2_wfi_m_not_illegal: assert (!in_m || !v_wait_irq.ill)
            else $error("R2: wait-for-interrupt illegal in M");
        a_r4_rsv_m_allowed: assert (!in_m || v_wait_rsv.allow)
            else $error("R4: wait-on-reservation blocked in M");
        a_r4_rsv_no_halt: assert (!v_wait_rsv.halt)
            else $error("R4: wait-on-reservation requested halt");
    end

endmodule

// File: rtl/priv_fence_rules.sv
// Verdicts for the supervisor fence and the two hypervisor fences.
// Combinational; the guest-physical fence adds one illegal check in
// front of the guest-virtual fence rules.
module priv_fence_rules
    import priv_gate_pkg::*;
(
    input  priv_e    priv,
    input  logic     virt_on,
    input  logic     trap_vm,
    input  logic     vtrap_vm,
    output verdict_t v_sfence,
    output verdict_t v_hfence_v,
    output verdict_t v_hfence_g
);

    logic in_u;
    logic in_s;
    logic in_m;

    // Decode privilege once for the three fences.
    always_comb begin
        in_u = (priv == PRIV_USER);
        in_s = (priv == PRIV_SUPER);
        in_m = (priv == PRIV_MACH);
    end

    // Supervisor fence: host illegal checks, then guest checks.
    always_comb begin
        if (!virt_on && (in_u || (in_s && trap_vm))) begin
            v_sfence = VERDICT_ILL;
        end else if (virt_on && (in_u || vtrap_vm)) begin
            v_sfence = VERDICT_VFLT;
        end else begin
            v_sfence = VERDICT_ALLOW;
        end
    end

    // Guest-virtual fence: any guest traps to the hypervisor.
    always_comb begin
        if (virt_on) begin
            v_hfence_v = VERDICT_VFLT;
        end else if (in_m || in_s) begin
            v_hfence_v = VERDICT_ALLOW;
        end else begin
            v_hfence_v = VERDICT_ILL;
        end
    end

    // Guest-physical fence: trap_vm in host S first, then guest-virtual rules.
    always_comb begin
        if (in_s && !virt_on && trap_vm) begin
            v_hfence_g = VERDICT_ILL;
        end else begin
            v_hfence_g = v_hfence_v;
        end
    end

    // Guard fence verdict relations.
    always_comb begin
        a_r6_guest_vfence_virt: assert (!virt_on || v_hfence_v.vflt)
            else $error("R6: guest fence not virtual-trapped");
        a_r5_sfence_host_m_ok: assert (!(in_m && !virt_on) || v_sfence.allow)
            else $error("R5: supervisor fence blocked in host M");
        a_r7_gfence_m_ok: assert (!(in_m && !virt_on) || v_hfence_g.allow)
            else $error("R7: guest-physical fence blocked in host M");
    end

endmodule

// File: rtl/priv_hyp_access_rules.sv
// Verdict for hypervisor guest loads and stores. Combinational; M wins
// over every other input.
module priv_hyp_access_rules
    import priv_gate_pkg::*;
(
    input  priv_e    priv,
    input  logic     virt_on,
    input  logic     hyp_user_ok,
    output verdict_t v_hyp_ldst
);

    // Priority chain: M, then guest, then user permission.
    always_comb begin
        if (priv == PRIV_MACH) begin
            v_hyp_ldst = VERDICT_ALLOW;
        end else if (virt_on) begin
            v_hyp_ldst = VERDICT_VFLT;
        end else if (priv == PRIV_USER && !hyp_user_ok) begin
            v_hyp_ldst = VERDICT_ILL;
        end else begin
            v_hyp_ldst = VERDICT_ALLOW;
        end
    end

    // Guard the M override.
    always_comb begin
        a_r8_m_always_ok: assert (priv != PRIV_MACH || v_hyp_ldst.allow)
            else $error("R8: hypervisor access blocked in M");
    end

endmodule

// File: rtl/priv_insn_gate.sv
// Top of the privileged instruction permission gate. Selects the verdict
// of the presented opcode class and encodes it as allow / exception /
// halt. Purely combinational; privilege value 2 must not be driven.
module priv_insn_gate
    import priv_gate_pkg::*;
#(
    parameter int CAUSE_W    = 5,
    parameter int ILL_CAUSE  = 2,
    parameter int VIRT_CAUSE = 22
) (
    input  logic [2:0]         op_class,
    input  logic [1:0]         priv,
    input  logic               virt_on,
    input  logic               smode_present,
    input  logic               trap_wait,
    input  logic               trap_vm,
    input  logic               vtrap_wait,
    input  logic               vtrap_vm,
    input  logic               hyp_user_ok,
    output logic               allow,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic               halt_req
);

    localparam logic [CAUSE_W-1:0] ILL_CODE  = CAUSE_W'(ILL_CAUSE);
    localparam logic [CAUSE_W-1:0] VIRT_CODE = CAUSE_W'(VIRT_CAUSE);

    priv_e    priv_q;
    opc_e     opc;
    verdict_t v_wait_irq, v_wait_rsv;
    verdict_t v_sfence, v_hfence_v, v_hfence_g;
    verdict_t v_hyp_ldst;
    verdict_t v_sel;

    assign priv_q = priv_e'(priv);
    assign opc    = opc_e'(op_class);

    priv_wait_rules u_wait (
        .priv          (priv_q),
        .virt_on       (virt_on),
        .smode_present (smode_present),
        .trap_wait     (trap_wait),
        .vtrap_wait    (vtrap_wait),
        .v_wait_irq    (v_wait_irq),
        .v_wait_rsv    (v_wait_rsv)
    );

    priv_fence_rules u_fence (
        .priv       (priv_q),
        .virt_on    (virt_on),
        .trap_vm    (trap_vm),
        .vtrap_vm   (vtrap_vm),
        .v_sfence   (v_sfence),
        .v_hfence_v (v_hfence_v),
        .v_hfence_g (v_hfence_g)
    );

    priv_hyp_access_rules u_hyp (
        .priv        (priv_q),
        .virt_on     (virt_on),
        .hyp_user_ok (hyp_user_ok),
        .v_hyp_ldst  (v_hyp_ldst)
    );

    // Pick the verdict of the presented class; none/reserved give nothing.
    always_comb begin
        unique case (opc)
            OPC_WAIT_IRQ: v_sel = v_wait_irq;
            OPC_WAIT_RSV: v_sel = v_wait_rsv;
            OPC_SFENCE:   v_sel = v_sfence;
            OPC_HFENCE_V: v_sel = v_hfence_v;
            OPC_HFENCE_G: v_sel = v_hfence_g;
            OPC_HYP_LDST: v_sel = v_hyp_ldst;
            default:      v_sel = VERDICT_NONE;
        endcase
    end

    // Encode the verdict onto the output pins.
    always_comb begin
        allow     = v_sel.allow;
        exc_valid = v_sel.ill | v_sel.vflt;
        halt_req  = v_sel.halt;
        if (v_sel.vflt) begin
            exc_cause = VIRT_CODE;
        end else if (v_sel.ill) begin
            exc_cause = ILL_CODE;
        end else begin
            exc_cause = '0;
        end
    end

    // Guard the output encoding.
    always_comb begin
        a_r9_allow_exc_exclusive: assert (!(allow && exc_valid))
            else $error("R9: allow and exception together");
        a_r9_cause_legal: assert (exc_valid ? (exc_cause == ILL_CODE || exc_cause == VIRT_CODE)
                                            : (exc_cause == '0))
            else $error("R9: bad cause %0d", exc_cause);
        a_r3_halt_only_wait_irq: assert (!halt_req || (opc == OPC_WAIT_IRQ && allow))
            else $error("R3: halt outside permitted wait-for-interrupt");
        a_r1_idle_silent: assert (!(opc == OPC_NONE || opc == OPC_RSVD) ||
                                  !(allow || exc_valid || halt_req))
            else $error("R1: idle class produced output");
    end

endmodule

// File: tb/priv_insn_gate_bench.sv
`timescale 1ns/1ps
module priv_insn_gate_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0] op_class;
    logic [1:0] priv;
    logic virt_on, smode_present, trap_wait, trap_vm, vtrap_wait, vtrap_vm, hyp_user_ok;
    logic allow, exc_valid, halt_req;
    logic [4:0] exc_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    priv_insn_gate u_priv_insn_gate (
        .op_class(op_class), .priv(priv), .virt_on(virt_on),
        .smode_present(smode_present), .trap_wait(trap_wait), .trap_vm(trap_vm),
        .vtrap_wait(vtrap_wait), .vtrap_vm(vtrap_vm), .hyp_user_ok(hyp_user_ok),
        .allow(allow), .exc_valid(exc_valid), .exc_cause(exc_cause), .halt_req(halt_req)
    );

    // Outcome: 0 nothing, 1 allow, 2 illegal, 3 virtual, 4 allow+halt.
    function automatic int expect_outcome(int op, int p, bit v, bit sm, bit tw,
                                          bit tvm, bit vtw, bit vtvm, bit hu);
        bit u = (p == 0);
        bit s = (p == 1);
        bit m = (p == 3);
        case (op)
            1: begin // R2, R3
                if (tw && s) return 2;
                if (tw && u && !sm) return 2;
                if (u && sm && !v) return 2;
                if (v && u) return 3;
                if (v && s && vtw) return 3;
                return 4;
            end
            2: begin // R4
                if (v && !m && vtw && !tw) return 3;
                if (tw && !m) return 2;
                return 1;
            end
            3: begin // R5
                if (!v) return (u || (s && tvm)) ? 2 : 1;
                return (u || vtvm) ? 3 : 1;
            end
            4: begin // R6
                if (v) return 3;
                return u ? 2 : 1;
            end
            5: begin // R7
                if (!v && s && tvm) return 2;
                if (v) return 3;
                return u ? 2 : 1;
            end
            6: begin // R8
                if (m) return 1;
                if (v) return 3;
                if (u && !hu) return 2;
                return 1;
            end
            default: return 0; // R1
        endcase
    endfunction

    function automatic string tag_of(int op);
        case (op)
            1: return "R2/R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic run_sweep();
        int privs[3] = '{0, 1, 3};
        for (int op = 0; op < 8; op++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int cfg = 0; cfg < 128; cfg++) begin
                    int exp_o;
                    logic [3:0] exp_vec, got_vec;
                    logic [4:0] exp_cause;
                    @(negedge clk);
                    op_class      = 3'(op);
                    priv          = 2'(privs[pi]);
                    virt_on       = cfg[0];
                    smode_present = cfg[1];
                    trap_wait     = cfg[2];
                    trap_vm       = cfg[3];
                    vtrap_wait    = cfg[4];
                    vtrap_vm      = cfg[5];
                    hyp_user_ok   = cfg[6];
                    exp_o = expect_outcome(op, privs[pi], cfg[0], cfg[1], cfg[2],
                                           cfg[3], cfg[4], cfg[5], cfg[6]);
                    exp_vec[3] = (exp_o == 1 || exp_o == 4);
                    exp_vec[2] = (exp_o == 2 || exp_o == 3);
                    exp_vec[1] = (exp_o == 4);
                    exp_vec[0] = 1'b0;
                    exp_cause  = (exp_o == 2) ? 5'd2 : (exp_o == 3) ? 5'd22 : 5'd0;
                    @(posedge clk);
                    #1;
                    got_vec = {allow, exc_valid, halt_req, 1'b0};
                    n_checks++;
                    if (got_vec !== exp_vec || exc_cause !== exp_cause) begin
                        n_fails++;
                        $display("FAIL %s op=%0d priv=%0d cfg=%b got allow/exc/halt=%b cause=%0d exp %b cause=%0d",
                                 tag_of(op), op, privs[pi], cfg[6:0], got_vec[3:1], exc_cause,
                                 exp_vec[3:1], exp_cause);
                    end
                    // R9: exclusivity checked on its own
                    n_checks++;
                    if (allow && exc_valid) begin
                        n_fails++;
                        $display("FAIL R9 op=%0d allow=%b exc_valid=%b exp not both", op, allow, exc_valid);
                    end
                end
            end
        end
    endtask

    initial begin
        op_class = 3'd0; priv = 2'd3; virt_on = 1'b0; smode_present = 1'b1;
        trap_wait = 1'b0; trap_vm = 1'b0; vtrap_wait = 1'b0; vtrap_vm = 1'b0;
        hyp_user_ok = 1'b0;
        @(posedge clk);
        #1;
        // R1: idle state before any instruction
        n_checks++;
        if (allow || exc_valid || halt_req || exc_cause != 5'd0) begin
            n_fails++;
            $display("FAIL R1 idle got %b%b%b cause=%0d exp 000 cause=0",
                     allow, exc_valid, halt_req, exc_cause);
        end
        run_sweep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired got running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule